// File: doc/BRIEF.md
# Paged macroblock inter-stage buffer

This block decouples two neighbouring stages of a macroblock processing pipeline. Its storage is a ring of pages. Each page holds one complete macroblock: a 16x16 luma block and its two 8x8 chroma blocks in 4:2:0 form. The producing stage fills the current fill page one sample at a time and hands it over with a commit pulse. The consuming stage works only on the oldest committed page and gives it back with a release pulse. Because the two stages touch different pages, both can run at full rate. The page count is a parameter and sets how many macroblocks the producer may run ahead of the consumer.

The consumer has two independent read ports into its page. It can therefore fetch two different rows of the same macroblock in one cycle. Each read port returns its sample one clock after the address is presented. A synchronous reset discards every page, committed or not.

Samples are addressed by a component code, a row and a column. Code 0 selects luma, with rows and columns 0..DIM-1. Code 1 selects Cb and code 2 selects Cr. For chroma, rows and columns run 0..DIM/2-1, and the top bit of the row and of the column is ignored. Code 3 addresses nothing.

Top module: `mb_page_buf`

## Requirements
- R1: After a synchronous reset `empty` is 1 and `full` is 0.
- R2: Component code 0 addresses luma at (row, col) over 0..15. Code 1 addresses Cb and code 2 addresses Cr, each over 0..7, and for chroma the top bit of row and of col is ignored. A write with code 3 changes nothing, and a read with code 3 returns 0.
- R3: `full` is 1 exactly when PAGES pages are committed and unreleased. While `full` is 1, both writes and commits are ignored.
- R4: `empty` is 1 when no committed page is waiting. A release while `empty` is 1 is ignored.
- R5: The read ports always address the oldest committed page. Pages reach the consumer in commit order, and page slots wrap modulo PAGES.
- R6: Both read ports return the sample at their own address one clock after that address is presented, and both do so in the same cycle.
- R7: A commit and a release in the same cycle leave the number of committed pages unchanged, with no page lost or duplicated.
- R8: A write issued in the same cycle as a commit lands in the page being committed.
- R9: Reset in the middle of operation empties all pages, and filling then resumes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one sample into the fill page |
| wr_comp | input | 2 | Write component code (0 luma, 1 Cb, 2 Cr) |
| wr_row | input | 4 | Write row |
| wr_col | input | 4 | Write column |
| wr_data | input | 8 | Write sample |
| commit | input | 1 | Hand the fill page to the consumer |
| full | output | 1 | All pages committed; producer must stall |
| rd_comp_a | input | 2 | Read port A component code |
| rd_row_a | input | 4 | Read port A row |
| rd_col_a | input | 4 | Read port A column |
| rd_data_a | output | 8 | Read port A sample, one clock after its address |
| rd_comp_b | input | 2 | Read port B component code |
| rd_row_b | input | 4 | Read port B row |
| rd_col_b | input | 4 | Read port B column |
| rd_data_b | output | 8 | Read port B sample, one clock after its address |
| rel | input | 1 | Release the oldest committed page |
| empty | output | 1 | No committed page waiting |

## Verification
The hardest case to reach from the ports is a write or a commit issued while the ring is full. In that state the fill slot coincides with the oldest committed page, so a wrongly accepted write would corrupt data the consumer has not yet read. The bench fills all three pages and then drives a write and a commit together. It then sweeps the oldest page completely to confirm it is untouched, and releases every page to show that no extra page appeared.

A second case is a commit and a release in the same cycle while the ring wraps around. The bench overlaps the final write and commit of a new page with the release of a page just read. It then drains the ring in order and compares every sample.

// File: rtl/mb_page_pkg.sv
package mb_page_pkg;

  typedef enum logic [1:0] {
    COMP_Y    = 2'd0,
    COMP_CB   = 2'd1,
    COMP_CR   = 2'd2,
    COMP_NONE = 2'd3
  } comp_e;

  // Samples held by one page for a DIM x DIM luma block in 4:2:0
  function automatic int unsigned page_words(input int unsigned dim);
    return dim * dim + 2 * (dim / 2) * (dim / 2);
  endfunction

  // Offset of a sample inside a page: luma first, then Cb, then Cr
  function automatic int unsigned page_offset(input logic [1:0] comp,
                                              input int unsigned row,
                                              input int unsigned col,
                                              input int unsigned dim);
    int unsigned h;
    h = dim / 2;
    case (comp)
      2'd0:    return row * dim + col;
      2'd1:    return dim * dim + (row % h) * h + (col % h);
      default: return dim * dim + h * h + (row % h) * h + (col % h);
    endcase
  endfunction

  // Ring index advance modulo the page count
  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/mb_page_ctrl.sv
module mb_page_ctrl #(
  parameter int PAGES = 3,
  localparam int PW   = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CNTW = $clog2(PAGES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic            rel,
  output logic [PW-1:0]   fill_pg,
  output logic [PW-1:0]   drain_pg,
  output logic [CNTW-1:0] occ,
  output logic            full,
  output logic            empty,
  output logic            commit_fire,
  output logic            release_fire
);
  import mb_page_pkg::*;

  assign full         = (occ == CNTW'(PAGES));
  assign empty        = (occ == '0);
  assign commit_fire  = commit && !full;
  assign release_fire = rel && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_pg  <= '0;
      drain_pg <= '0;
      occ      <= '0;
    end else begin
      if (commit_fire)
        fill_pg <= PW'(ring_next(int'(fill_pg), PAGES));
      if (release_fire)
        drain_pg <= PW'(ring_next(int'(drain_pg), PAGES));
      case ({commit_fire, release_fire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/mb_page_addr.sv
module mb_page_addr #(
  parameter int PAGES = 3,
  parameter int DIM   = 16,
  localparam int PW   = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CW   = $clog2(DIM),
  localparam int DEPTH = PAGES * mb_page_pkg::page_words(DIM),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [PW-1:0] page,
  input  logic [1:0]    comp,
  input  logic [CW-1:0] row,
  input  logic [CW-1:0] col,
  output logic [AW-1:0] addr,
  output logic          valid
);
  import mb_page_pkg::*;

  localparam int unsigned WORDS = page_words(DIM);

  always_comb begin
    valid = (comp != COMP_NONE);
    addr  = AW'(int'(page) * WORDS + page_offset(comp, int'(row), int'(col), DIM));
  end

endmodule

// File: rtl/mb_page_store.sv
module mb_page_store #(
  parameter int SW    = 8,
  parameter int DEPTH = 1152,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [SW-1:0]           wdata,
  input  logic [NRD-1:0]          rok,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][SW-1:0]  rdata
);

  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= rok[p] ? mem[raddr[p]] : '0;
    end
  end

endmodule

// File: rtl/mb_page_buf.sv
module mb_page_buf #(
  parameter int PAGES = 3,
  parameter int SW    = 8,
  parameter int DIM   = 16,
  localparam int CW   = $clog2(DIM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_comp,
  input  logic [CW-1:0] wr_row,
  input  logic [CW-1:0] wr_col,
  input  logic [SW-1:0] wr_data,
  input  logic          commit,
  output logic          full,
  input  logic [1:0]    rd_comp_a,
  input  logic [CW-1:0] rd_row_a,
  input  logic [CW-1:0] rd_col_a,
  output logic [SW-1:0] rd_data_a,
  input  logic [1:0]    rd_comp_b,
  input  logic [CW-1:0] rd_row_b,
  input  logic [CW-1:0] rd_col_b,
  output logic [SW-1:0] rd_data_b,
  input  logic          rel,
  output logic          empty
);
  import mb_page_pkg::*;

  localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int CNTW  = $clog2(PAGES + 1);
  localparam int DEPTH = PAGES * page_words(DIM);
  localparam int AW    = $clog2(DEPTH);
  localparam int NRD   = 2;

  // Internal events brought out for the checker
  logic [PW-1:0]   fill_pg;
  logic [PW-1:0]   drain_pg;
  logic [CNTW-1:0] occ;
  logic            commit_fire;
  logic            release_fire;
  logic            wr_fire;

  logic [AW-1:0]            waddr;
  logic                     wvalid;
  logic [NRD-1:0][1:0]      rcomp;
  logic [NRD-1:0][CW-1:0]   rrow;
  logic [NRD-1:0][CW-1:0]   rcol;
  logic [NRD-1:0][AW-1:0]   raddr;
  logic [NRD-1:0]           rok;
  logic [NRD-1:0][SW-1:0]   rdata;

  mb_page_ctrl #(.PAGES(PAGES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .commit       (commit),
    .rel          (rel),
    .fill_pg      (fill_pg),
    .drain_pg     (drain_pg),
    .occ          (occ),
    .full         (full),
    .empty        (empty),
    .commit_fire  (commit_fire),
    .release_fire (release_fire)
  );

  mb_page_addr #(.PAGES(PAGES), .DIM(DIM)) u_waddr (
    .page  (fill_pg),
    .comp  (wr_comp),
    .row   (wr_row),
    .col   (wr_col),
    .addr  (waddr),
    .valid (wvalid)
  );

  assign wr_fire = wr_en && !full && wvalid;

  assign rcomp[0] = rd_comp_a;
  assign rrow[0]  = rd_row_a;
  assign rcol[0]  = rd_col_a;
  assign rcomp[1] = rd_comp_b;
  assign rrow[1]  = rd_row_b;
  assign rcol[1]  = rd_col_b;

  for (genvar p = 0; p < NRD; p++) begin : g_raddr
    mb_page_addr #(.PAGES(PAGES), .DIM(DIM)) u_raddr (
      .page  (drain_pg),
      .comp  (rcomp[p]),
      .row   (rrow[p]),
      .col   (rcol[p]),
      .addr  (raddr[p]),
      .valid (rok[p])
    );
  end

  mb_page_store #(.SW(SW), .DEPTH(DEPTH), .NRD(NRD)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (waddr),
    .wdata (wr_data),
    .rok   (rok),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign rd_data_a = rdata[0];
  assign rd_data_b = rdata[1];

endmodule

// File: rtl/mb_page_buf_chk.sv
module mb_page_buf_chk #(
  parameter int PAGES = 3,
  localparam int CNTW = $clog2(PAGES + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            commit,
  input logic            rel,
  input logic            full,
  input logic            empty,
  input logic [CNTW-1:0] occ,
  input logic            commit_fire,
  input logic            release_fire
);

  // R1: reset leaves the ring empty
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (empty && !full && occ == '0));

  // R3: occupancy never exceeds the page count
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (rst)
    occ <= CNTW'(PAGES));

  // R3: full cannot clear without a release
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !rel) |=> full);

  // R4: empty cannot clear without a commit
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && !commit) |=> empty);

  // R5: a lone commit adds exactly one page
  p_commit_step_r5: assert property (@(posedge clk) disable iff (rst)
    (commit_fire && !release_fire) |=> occ == $past(occ) + 1'b1);

  // R7: commit with release keeps occupancy
  p_simul_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_fire && release_fire) |=> $stable(occ));

endmodule

bind mb_page_buf mb_page_buf_chk #(.PAGES(PAGES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .commit       (commit),
  .rel          (rel),
  .full         (full),
  .empty        (empty),
  .occ          (occ),
  .commit_fire  (commit_fire),
  .release_fire (release_fire)
);

// File: tb/mb_page_buf_tb.sv
module mb_page_buf_tb;

  localparam int DIM = 16;
  localparam int H   = DIM / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_comp = '0;
  logic [3:0] wr_row = '0, wr_col = '0;
  logic [7:0] wr_data = '0;
  logic       commit = 1'b0;
  logic       full;
  logic [1:0] rd_comp_a = '0, rd_comp_b = '0;
  logic [3:0] rd_row_a = '0, rd_col_a = '0, rd_row_b = '0, rd_col_b = '0;
  logic [7:0] rd_data_a, rd_data_b;
  logic       rel = 1'b0;
  logic       empty;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mb_page_buf u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_comp(wr_comp), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data), .commit(commit), .full(full),
    .rd_comp_a(rd_comp_a), .rd_row_a(rd_row_a), .rd_col_a(rd_col_a), .rd_data_a(rd_data_a),
    .rd_comp_b(rd_comp_b), .rd_row_b(rd_row_b), .rd_col_b(rd_col_b), .rd_data_b(rd_data_b),
    .rel(rel), .empty(empty)
  );

  function automatic logic [7:0] pat(input int tag, input int c, input int r, input int k);
    return 8'((tag * 37 + c * 91 + r * 13 + k * 7) % 256);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input bit exp_full, input bit exp_empty);
    check({req, " full"}, int'(full), int'(exp_full));
    check({req, " empty"}, int'(empty), int'(exp_empty));
  endtask

  // Fill every sample of the fill page; the last write may carry commit and release (R8, R7)
  task automatic write_page(input int tag, input bit do_commit, input bit do_rel);
    for (int c = 0; c < 3; c++) begin
      for (int r = 0; r < ((c == 0) ? DIM : H); r++) begin
        for (int k = 0; k < ((c == 0) ? DIM : H); k++) begin
          wr_en   = 1'b1;
          wr_comp = 2'(c);
          wr_row  = 4'(r);
          wr_col  = 4'(k);
          wr_data = pat(tag, c, r, k);
          if (c == 2 && r == H - 1 && k == H - 1) begin
            commit = do_commit;
            rel    = do_rel;
          end
          @(negedge clk);
        end
      end
    end
    wr_en  = 1'b0;
    commit = 1'b0;
    rel    = 1'b0;
  endtask

  // Sweep the oldest page on both ports, port B one row ahead (R2, R5, R6)
  task automatic read_page(input int tag);
    for (int c = 0; c < 3; c++) begin
      for (int r = 0; r < ((c == 0) ? DIM : H); r++) begin
        for (int k = 0; k < ((c == 0) ? DIM : H); k++) begin
          automatic int d  = (c == 0) ? DIM : H;
          automatic int rb = (r + 1) % d;
          rd_comp_a = 2'(c); rd_row_a = 4'(r);  rd_col_a = 4'(k);
          rd_comp_b = 2'(c); rd_row_b = 4'(rb); rd_col_b = 4'(k);
          @(negedge clk);
          check("R5 R6 port A", int'(rd_data_a), int'(pat(tag, c, r, k)));
          check("R2 R6 port B", int'(rd_data_b), int'(pat(tag, c, rb, k)));
        end
      end
    end
  endtask

  task automatic pulse_rel();
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
  endtask

  task automatic pulse_commit();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check_flags("R1 after reset", 1'b0, 1'b1);

    // Fill the ring completely
    write_page(1, 1'b1, 1'b0);
    check_flags("R3 one page", 1'b0, 1'b0);
    write_page(2, 1'b1, 1'b0);
    write_page(3, 1'b1, 1'b0);
    check_flags("R3 all pages", 1'b1, 1'b0);

    // Write and commit while full must be ignored (R3)
    wr_en = 1'b1; wr_comp = 2'd0; wr_row = 4'd0; wr_col = 4'd0; wr_data = 8'hEE;
    commit = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; commit = 1'b0;
    check_flags("R3 commit while full", 1'b1, 1'b0);
    read_page(1);
    pulse_rel();
    check_flags("R3 after release", 1'b0, 1'b0);

    // Commit and release together while wrapping (R7, R8)
    read_page(2);
    write_page(4, 1'b1, 1'b1);
    check_flags("R7 simultaneous", 1'b0, 1'b0);
    read_page(3);
    pulse_rel();
    read_page(4);
    pulse_rel();
    check_flags("R7 drained", 1'b0, 1'b1);

    // Release while empty is ignored (R4)
    pulse_rel();
    check_flags("R4 release while empty", 1'b0, 1'b1);
    write_page(5, 1'b1, 1'b0);
    read_page(5);
    pulse_rel();
    check_flags("R4 after page five", 1'b0, 1'b1);

    // Chroma aliasing and component code 3 (R2)
    write_page(6, 1'b0, 1'b0);
    wr_en = 1'b1; wr_comp = 2'd1; wr_row = 4'd9; wr_col = 4'd10; wr_data = 8'h5A;
    @(negedge clk);
    wr_comp = 2'd3; wr_row = 4'd0; wr_col = 4'd0; wr_data = 8'h77;
    @(negedge clk);
    wr_en = 1'b0;
    pulse_commit();
    rd_comp_a = 2'd1; rd_row_a = 4'd1; rd_col_a = 4'd2;
    rd_comp_b = 2'd3; rd_row_b = 4'd0; rd_col_b = 4'd0;
    @(negedge clk);
    check("R2 chroma alias", int'(rd_data_a), 8'h5A);
    check("R2 code 3 read", int'(rd_data_b), 0);
    rd_comp_a = 2'd2; rd_row_a = 4'd0; rd_col_a = 4'd0;
    rd_comp_b = 2'd0; rd_row_b = 4'd0; rd_col_b = 4'd0;
    @(negedge clk);
    check("R2 code 3 write ignored cr", int'(rd_data_a), int'(pat(6, 2, 0, 0)));
    check("R2 code 3 write ignored y", int'(rd_data_b), int'(pat(6, 0, 0, 0)));
    pulse_rel();

    // Reset in mid operation (R9)
    write_page(7, 1'b1, 1'b0);
    write_page(8, 1'b1, 1'b0);
    check_flags("R9 before reset", 1'b0, 1'b0);
    do_reset();
    check_flags("R9 after reset", 1'b0, 1'b1);
    write_page(9, 1'b1, 1'b0);
    check_flags("R9 refill", 1'b0, 1'b0);
    read_page(9);
    pulse_rel();
    check_flags("R9 drained", 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule